// File: doc/BRIEF.md
# Load-Use Stall Detector

This block sits beside the decode stage of a five-stage in-order pipeline. It compares the destination register of a load that currently occupies the execute stage with the two source registers of the instruction being decoded. If the decoded instruction reads a value that the load will only deliver after its memory access, the block freezes the program counter and the fetch/decode register for one cycle. In that cycle it also turns the decoded instruction into a bubble by clearing the control bundle that is about to be written into the decode/execute register.

The stalled instruction is decoded again in the next cycle. By then the bubble sits in the execute stage with its load-enable bit clear, so no second stall is raised. The load's result then reaches the instruction through the memory/writeback bypass, which lives outside this block. Register 0 is hard-wired to zero, so a match on it never stalls. Generation of the bubble has two variants. One clears the whole control bundle. The other clears only the three bits whose side effects matter and lets the other bits through.

Top module: `load_use_guard`

## Requirements
- R1: When `ex_is_load` is 1, `ex_dst` is nonzero and `ex_dst` equals `id_src_a`, a stall is raised.
- R2: When `ex_is_load` is 1, `ex_dst` is nonzero and `ex_dst` equals `id_src_b`, a stall is raised.
- R3: When `ex_is_load` is 0, no stall is raised, even if the register numbers match.
- R4: When `ex_dst` is 0, no stall is raised, even with a load and matching sources.
- R5: A stall drives `pc_en`=0, `fd_en`=0 and `bubble`=1 in the same cycle. With no stall these are 1, 1 and 0.
- R6: With `CLEAR_ALL`=1, `dx_ctrl` is all zeros during a stall.
- R7: With `CLEAR_ALL`=0, a stall clears only the register-write bit (bit `RW_BIT`, default 0), the memory-write bit (bit `MW_BIT`, default 1) and the load bit (bit `MR_BIT`, default 2) of `dx_ctrl`. All other bits equal `dec_ctrl`.
- R8: With no stall, `dx_ctrl` equals `dec_ctrl` in both variants.
- R9: When the bubble's load bit is fed back as the next cycle's `ex_is_load`, a load-use pair stalls for exactly one cycle. The held instruction then proceeds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; only the checks use it |
| rst_n | input | 1 | Active-low reset; only the checks use it |
| ex_is_load | input | 1 | Load bit of the instruction in the execute stage |
| ex_dst | input | AW | Destination register of the instruction in the execute stage |
| id_src_a | input | AW | First source register of the instruction in decode |
| id_src_b | input | AW | Second source register of the instruction in decode |
| dec_ctrl | input | CW | Control bundle produced by the decoder |
| pc_en | output | 1 | Program counter update enable |
| fd_en | output | 1 | Fetch/decode register update enable |
| bubble | output | 1 | High when the control bundle is being cleared |
| dx_ctrl | output | CW | Control bundle to write into the decode/execute register |

## Verification
The bench builds two copies of the block. Both use 5-bit register numbers and a 9-bit control bundle. One copy clears the whole bundle (`CLEAR_ALL`=1) and the other clears only the three side-effect bits (`CLEAR_ALL`=0). Running both copies on the same stimulus reaches both bubble variants. It also shows that the partial variant must still clear the load bit. A small model of the decode/execute register fed back into the block reaches the single-cycle stall length.

// File: rtl/load_use_guard.sv
module load_use_guard #(
  parameter int AW        = 5,
  parameter int CW        = 9,
  parameter int RW_BIT    = 0,
  parameter int MW_BIT    = 1,
  parameter int MR_BIT    = 2,
  parameter bit CLEAR_ALL = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ex_is_load,
  input  logic [AW-1:0] ex_dst,
  input  logic [AW-1:0] id_src_a,
  input  logic [AW-1:0] id_src_b,
  input  logic [CW-1:0] dec_ctrl,
  output logic          pc_en,
  output logic          fd_en,
  output logic          bubble,
  output logic [CW-1:0] dx_ctrl
);

  localparam logic [AW-1:0] ZERO_REG = '0;

  logic hit_a, hit_b, stall;
  logic [CW-1:0] keep_mask;

  assign hit_a  = (ex_dst == id_src_a);
  assign hit_b  = (ex_dst == id_src_b);
  assign stall  = ex_is_load && (ex_dst != ZERO_REG) && (hit_a || hit_b);

  assign pc_en  = !stall;
  assign fd_en  = !stall;
  assign bubble = stall;

  generate
    if (CLEAR_ALL) begin : g_full
      assign keep_mask = '0;
    end else begin : g_part
      for (genvar i = 0; i < CW; i++) begin : g_bit
        assign keep_mask[i] = !(i == RW_BIT || i == MW_BIT || i == MR_BIT);
      end
    end
  endgenerate

  assign dx_ctrl = stall ? (dec_ctrl & keep_mask) : dec_ctrl;

  // R1 and R2: a load writing a nonzero source register of the decoded op holds the front end
  a_r1_r2_stall_on_hit: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_is_load && ex_dst != '0 && (ex_dst == id_src_a || ex_dst == id_src_b)) |-> (!pc_en && !fd_en));

  // R3: no load means no stall
  a_r3_no_load_no_stall: assert property (@(posedge clk) disable iff (!rst_n)
    !ex_is_load |-> (pc_en && fd_en && !bubble));

  // R4: register zero never stalls
  a_r4_reg_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_dst == '0) |-> pc_en);

  // R5: the three stall outputs agree
  a_r5_outputs_agree: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_en == fd_en) && (bubble == !pc_en));

  // R6 and R7: a bubble never carries a write or a load
  a_r7_bubble_inert: assert property (@(posedge clk) disable iff (!rst_n)
    bubble |-> (!dx_ctrl[RW_BIT] && !dx_ctrl[MW_BIT] && !dx_ctrl[MR_BIT]));

  // R8: no stall leaves the bundle untouched
  a_r8_pass_through: assert property (@(posedge clk) disable iff (!rst_n)
    pc_en |-> (dx_ctrl == dec_ctrl));

endmodule

// File: tb/load_use_guard_bench.sv
module load_use_guard_bench;
  localparam int AW = 5;
  localparam int CW = 9;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ex_is_load = 1'b0;
  logic [AW-1:0] ex_dst = '0, id_src_a = '0, id_src_b = '0;
  logic [CW-1:0] dec_ctrl = '0;
  logic pc_en, fd_en, bubble, pc_en_p, fd_en_p, bubble_p;
  logic [CW-1:0] dx_ctrl, dx_ctrl_p;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  load_use_guard #(.AW(AW), .CW(CW), .CLEAR_ALL(1'b1)) u_load_use_guard (
    .clk(clk), .rst_n(rst_n), .ex_is_load(ex_is_load), .ex_dst(ex_dst),
    .id_src_a(id_src_a), .id_src_b(id_src_b), .dec_ctrl(dec_ctrl),
    .pc_en(pc_en), .fd_en(fd_en), .bubble(bubble), .dx_ctrl(dx_ctrl));

  load_use_guard #(.AW(AW), .CW(CW), .CLEAR_ALL(1'b0)) u_load_use_guard_part (
    .clk(clk), .rst_n(rst_n), .ex_is_load(ex_is_load), .ex_dst(ex_dst),
    .id_src_a(id_src_a), .id_src_b(id_src_b), .dec_ctrl(dec_ctrl),
    .pc_en(pc_en_p), .fd_en(fd_en_p), .bubble(bubble_p), .dx_ctrl(dx_ctrl_p));

  // {load, ex_dst, src_a, src_b, expected_stall, tag}
  localparam int NV = 10;
  localparam logic [20:0] VEC [NV] = '{
    {1'b1, 5'd7,  5'd7,  5'd3,  1'b1, 4'd1},
    {1'b1, 5'd9,  5'd2,  5'd9,  1'b1, 4'd2},
    {1'b1, 5'd31, 5'd31, 5'd31, 1'b1, 4'd1},
    {1'b0, 5'd7,  5'd7,  5'd7,  1'b0, 4'd3},
    {1'b0, 5'd4,  5'd4,  5'd1,  1'b0, 4'd3},
    {1'b1, 5'd0,  5'd0,  5'd0,  1'b0, 4'd4},
    {1'b1, 5'd0,  5'd0,  5'd6,  1'b0, 4'd4},
    {1'b1, 5'd5,  5'd6,  5'd4,  1'b0, 4'd5},
    {1'b1, 5'd1,  5'd2,  5'd3,  1'b0, 4'd5},
    {1'b1, 5'd16, 5'd17, 5'd16, 1'b1, 4'd2}
  };

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_outputs(input bit exp_stall, input string req);
    logic [CW-1:0] exp_full, exp_part;
    exp_full = exp_stall ? '0 : dec_ctrl;
    exp_part = exp_stall ? (dec_ctrl & 9'h1F8) : dec_ctrl;
    check({pc_en, fd_en, bubble} == {!exp_stall, !exp_stall, exp_stall}, req,
          {pc_en, fd_en, bubble}, {!exp_stall, !exp_stall, exp_stall});
    check(dx_ctrl == exp_full, exp_stall ? "R6" : "R8", dx_ctrl, exp_full);
    check(dx_ctrl_p == exp_part, exp_stall ? "R7" : "R8", dx_ctrl_p, exp_part);
  endtask

  initial begin
    #200000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    dec_ctrl = 9'h1FF;
    #1;
    check({pc_en, fd_en, bubble, dx_ctrl} == {3'b110, 9'h1FF}, "R8 reset",
          {pc_en, fd_en, bubble, dx_ctrl}, {3'b110, 9'h1FF});
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      {ex_is_load, ex_dst, id_src_a, id_src_b} = VEC[i][20:5];
      dec_ctrl = 9'(i * 37 + 9'h0A5);
      #1;
      check_outputs(VEC[i][4], $sformatf("R%0d", VEC[i][3:0]));
    end

    // R7: partial variant keeps upper bits, clears bits 0..2
    @(negedge clk);
    ex_is_load = 1'b1; ex_dst = 5'd12; id_src_a = 5'd12; id_src_b = 5'd0;
    dec_ctrl = 9'h1FF;
    #1;
    check(dx_ctrl_p == 9'h1F8, "R7", dx_ctrl_p, 9'h1F8);
    check(dx_ctrl == 9'h000, "R6", dx_ctrl, 9'h000);

    // R9: closed loop with a model of the decode/execute register
    begin
      int stalls;
      logic [AW-1:0] held_b;
      stalls = 0;
      @(negedge clk);
      ex_is_load = 1'b1; ex_dst = 5'd8; id_src_a = 5'd3; id_src_b = 5'd8;
      dec_ctrl = 9'h007;
      for (int c = 0; c < 4; c++) begin
        logic nxt_load;
        #1;
        if (!pc_en) stalls++;
        nxt_load = dx_ctrl[2];
        held_b = id_src_b;
        @(negedge clk);
        ex_is_load = nxt_load;
        ex_dst = held_b;
        if (c >= 1) begin
          id_src_a = 5'd20; id_src_b = 5'd21; dec_ctrl = 9'h001;
        end
      end
      check(stalls == 1, "R9", stalls, 1);
    end

    // R4: load into register zero with zero sources on both ports
    @(negedge clk);
    ex_is_load = 1'b1; ex_dst = 5'd0; id_src_a = 5'd0; id_src_b = 5'd0;
    dec_ctrl = 9'h155;
    #1;
    check_outputs(1'b0, "R4");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule